// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block keeps a pending flag and a permission flag for each of nine interrupt sources: four external pins (A, B, C, D), a basic timer, a serial port, an event counter, a pulse generator and a watch timer. A source's vectored request is live while both of its flags are 1. Any live request raises a wake line for the standby logic, whether or not interrupts are globally enabled. A fixed-priority selector turns the live requests into one vector index and one CPU request line. The CPU request line is gated by a global master enable.

Software reaches the flags through a small command port. It can set or clear one pending flag, set or clear one permission flag, read or write any flag in 4-bit groups, and do an atomic test-and-clear of one pending flag. A pending flag set by software behaves exactly like a hardware request. When the CPU takes a vector, it pulses an acknowledge with the vector index, and the block clears the serviced pending flag. The basic timer and pin D share vector 0. On that vector, only one of the two flags is cleared, so the other stays pending.

Top module: `vint_flag_ctrl`

## Requirements
- R1: Reset, asynchronous and active low, clears all nine pending flags and all nine permission flags. After reset every output is 0 and every group read returns 0.
- R2: A 1 on `hw_req[i]` at a clock edge makes pending flag i equal to 1 after that edge. The flag then stays 1 until something clears it. Source indices: 0 pin A, 1 pin B, 2 pin C, 3 pin D, 4 basic timer, 5 serial, 6 event counter, 7 pulse generator, 8 watch timer.
- R3: `src_vrq[i]` is 1 exactly while pending flag i and permission flag i are both 1. `wake` is 1 whenever any `src_vrq` bit is 1, independent of `master_en`.
- R4: `cpu_vec` is the highest-priority vector that has a live request, or 0 if none has one. Vector numbers, highest priority first: 0 = basic timer or pin D, 1 = pin A, 2 = pin B, 3 = serial, 4 = event counter, 5 = pulse generator, 6 = watch timer, 7 = pin C. `cpu_req` is `master_en` AND (any vector has a live request).
- R5: When `ack_valid` is 1 with a single-source vector on `ack_vec`, that source's pending flag is cleared at the edge.
- R6: An acknowledge of vector 0 clears the basic timer flag if the basic timer request is live. Otherwise it clears the pin D flag if the pin D request is live. The other flag of the pair is left unchanged.
- R7: The command `reg_op`=1 (set pending) with `reg_addr`=i sets pending flag i. If permission flag i is 1, this raises a vectored request exactly as a hardware request would.
- R8: The command `reg_op`=5 (test-and-clear) with `reg_addr`=i shows pending flag i on `reg_rdata[0]` in the same cycle, with the upper bits 0, and clears that flag at the edge. If `hw_req[i]` is 1 in the same cycle, the flag stays 1.
- R9: The commands `reg_op`=3 and `reg_op`=4 set and clear permission flag `reg_addr`. The command `reg_op`=2 clears pending flag `reg_addr`. The command `reg_op`=0 does nothing.
- R10: The command `reg_op`=6 (group read) returns group `reg_addr` on `reg_rdata`, combinationally. The command `reg_op`=7 (group write) loads `reg_wdata` into group `reg_addr`. Groups 0, 1 and 2 hold pending flags 3..0, 7..4 and 8 (bits 3..1 read 0). Groups 3, 4 and 5 hold the permission flags in the same layout.
- R11: A hardware set of a pending flag wins over any clear of that flag in the same cycle, whether the clear comes from an acknowledge, a command or a group write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 9 | Per-source request pulses |
| master_en | input | 1 | Global interrupt enable for the CPU request |
| reg_op | input | 3 | Command code |
| reg_addr | input | 4 | Flag index or group index |
| reg_wdata | input | 4 | Group write data |
| reg_rdata | output | 4 | Group read or test-and-clear result |
| ack_valid | input | 1 | CPU took a vector |
| ack_vec | input | 3 | Index of the vector taken |
| src_vrq | output | 9 | Per-source vectored requests |
| cpu_req | output | 1 | Gated request to the CPU |
| cpu_vec | output | 3 | Selected vector index |
| wake | output | 1 | Standby release |

## Verification
The bench first acknowledges vector 0 with both of its sources live, then with only pin D enabled. A design that cleared both flags would lose an interrupt, and one that cleared a disabled timer flag would leave pin D pending forever. The bench races a test-and-clear and a clear command against a hardware set of the same flag; a design that let the clear win would drop the request. It also arms a source through a software set and checks that a vector follows. It checks that `wake` stays high while `master_en` is 0, and that a reset in the middle of a run leaves every group empty.

// File: rtl/vif_pkg.sv
`timescale 1ns/1ps
package vif_pkg;
    localparam int NSRC = 9;
    localparam int NVEC = 8;
    localparam int VW   = $clog2(NVEC);
    localparam int GW   = 4;
    localparam int AW   = 4;
    localparam int NGRP = (NSRC + GW - 1) / GW;
    localparam int PADW = NGRP * GW;

    localparam int SRC_PIN_A = 0;
    localparam int SRC_PIN_B = 1;
    localparam int SRC_PIN_C = 2;
    localparam int SRC_PIN_D = 3;
    localparam int SRC_BTMR  = 4;
    localparam int SRC_SER   = 5;
    localparam int SRC_EVC   = 6;
    localparam int SRC_PGEN  = 7;
    localparam int SRC_WTMR  = 8;

    localparam int VEC_SHARED = 0;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_SETR = 3'd1,
        OP_CLRR = 3'd2,
        OP_SETE = 3'd3,
        OP_CLRE = 3'd4,
        OP_TSTC = 3'd5,
        OP_GRD  = 3'd6,
        OP_GWR  = 3'd7
    } op_e;

    typedef struct packed {
        logic [NSRC-1:0] req;
        logic [NSRC-1:0] en;
    } flags_t;

    function automatic int vec_of_src(int s);
        case (s)
            SRC_PIN_A: return 1;
            SRC_PIN_B: return 2;
            SRC_PIN_C: return 7;
            SRC_PIN_D: return 0;
            SRC_BTMR:  return 0;
            SRC_SER:   return 3;
            SRC_EVC:   return 4;
            SRC_PGEN:  return 5;
            SRC_WTMR:  return 6;
            default:   return 0;
        endcase
    endfunction

    function automatic logic [NSRC-1:0] src_mask_of_vec(int v);
        logic [NSRC-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (vec_of_src(s) == v) m[s] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/vif_reg_port.sv
`timescale 1ns/1ps
module vif_reg_port
    import vif_pkg::*;
(
    input  op_e             op,
    input  logic [AW-1:0]   addr,
    input  logic [GW-1:0]   wdata,
    input  logic [NSRC-1:0] req_q,
    input  logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] req_set,
    output logic [NSRC-1:0] req_clr,
    output logic [NSRC-1:0] en_set,
    output logic [NSRC-1:0] en_clr,
    output logic [GW-1:0]   rdata
);
    logic [NSRC-1:0] bit_sel;
    logic [PADW-1:0] req_pad, en_pad;
    logic [PADW-1:0] grp_req_set, grp_req_clr, grp_en_set, grp_en_clr;

    assign req_pad = PADW'(req_q);
    assign en_pad  = PADW'(en_q);

    always_comb begin
        bit_sel     = NSRC'(1) << addr;
        grp_req_set = '0;
        grp_req_clr = '0;
        grp_en_set  = '0;
        grp_en_clr  = '0;
        rdata       = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (addr == AW'(g)) begin
                if (op == OP_GRD) rdata = req_pad[g*GW +: GW];
                if (op == OP_GWR) begin
                    grp_req_set[g*GW +: GW] = wdata;
                    grp_req_clr[g*GW +: GW] = ~wdata;
                end
            end
            if (addr == AW'(g + NGRP)) begin
                if (op == OP_GRD) rdata = en_pad[g*GW +: GW];
                if (op == OP_GWR) begin
                    grp_en_set[g*GW +: GW] = wdata;
                    grp_en_clr[g*GW +: GW] = ~wdata;
                end
            end
        end
        if (op == OP_TSTC) rdata = GW'(|(req_q & bit_sel));
        req_set = grp_req_set[NSRC-1:0] | ((op == OP_SETR) ? bit_sel : '0);
        req_clr = grp_req_clr[NSRC-1:0]
                | (((op == OP_CLRR) || (op == OP_TSTC)) ? bit_sel : '0);
        en_set  = grp_en_set[NSRC-1:0]  | ((op == OP_SETE) ? bit_sel : '0);
        en_clr  = grp_en_clr[NSRC-1:0]  | ((op == OP_CLRE) ? bit_sel : '0);
    end
endmodule

// File: rtl/vif_ack_clr.sv
`timescale 1ns/1ps
module vif_ack_clr
    import vif_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_valid,
    input  logic [VW-1:0]   ack_vec,
    input  logic [NSRC-1:0] vrq,
    output logic [NSRC-1:0] clr
);
    logic hit_shared;
    assign hit_shared = ack_valid && (ack_vec == VW'(VEC_SHARED));

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int V = vec_of_src(s);
        if (s == SRC_BTMR) begin : g_bt
            assign clr[s] = hit_shared & vrq[SRC_BTMR];
        end else if (s == SRC_PIN_D) begin : g_pd
            assign clr[s] = hit_shared & vrq[SRC_PIN_D] & ~vrq[SRC_BTMR];
        end else begin : g_one
            assign clr[s] = ack_valid && (ack_vec == VW'(V));
        end
    end

    // R6: a shared-vector acknowledge clears at most one of the pair
    p_shared_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr[SRC_BTMR], clr[SRC_PIN_D]}));
endmodule

// File: rtl/vif_vec_arb.sv
`timescale 1ns/1ps
module vif_vec_arb
    import vif_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] vrq,
    input  logic            master_en,
    output logic [NVEC-1:0] vec_pend,
    output logic [VW-1:0]   cpu_vec,
    output logic            cpu_req
);
    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        localparam logic [NSRC-1:0] M = src_mask_of_vec(v);
        assign vec_pend[v] = |(vrq & M);
    end

    always_comb begin
        cpu_vec = '0;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (vec_pend[v]) cpu_vec = VW'(v);
        end
        cpu_req = master_en & (|vec_pend);
    end

    // R4: a request to the CPU needs the master enable and a live chosen vector
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (master_en && vec_pend[cpu_vec]));
    // R4: no vector of higher priority than the chosen one is live
    p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ((vec_pend & ((NVEC'(1) << cpu_vec) - NVEC'(1))) == '0));
endmodule

// File: rtl/vint_flag_ctrl.sv
`timescale 1ns/1ps
module vint_flag_ctrl
    import vif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [8:0]  hw_req,
    input  logic        master_en,
    input  logic [2:0]  reg_op,
    input  logic [3:0]  reg_addr,
    input  logic [3:0]  reg_wdata,
    output logic [3:0]  reg_rdata,
    input  logic        ack_valid,
    input  logic [2:0]  ack_vec,
    output logic [8:0]  src_vrq,
    output logic        cpu_req,
    output logic [2:0]  cpu_vec,
    output logic        wake
);
    flags_t          st_d, st_q;
    logic [NSRC-1:0] sw_req_set, sw_req_clr, sw_en_set, sw_en_clr, ack_clr;
    logic [NVEC-1:0] vec_pend;
    logic [NSRC-1:0] tc_mask;
    op_e             op;

    assign op = op_e'(reg_op);

    vif_reg_port u_port (
        .op      (op),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .req_q   (st_q.req),
        .en_q    (st_q.en),
        .req_set (sw_req_set),
        .req_clr (sw_req_clr),
        .en_set  (sw_en_set),
        .en_clr  (sw_en_clr),
        .rdata   (reg_rdata)
    );

    vif_ack_clr u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec),
        .vrq       (src_vrq),
        .clr       (ack_clr)
    );

    vif_vec_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .vrq       (src_vrq),
        .master_en (master_en),
        .vec_pend  (vec_pend),
        .cpu_vec   (cpu_vec),
        .cpu_req   (cpu_req)
    );

    assign src_vrq = st_q.req & st_q.en;
    assign wake    = |src_vrq;

    always_comb begin
        st_d     = st_q;
        st_d.req = (st_q.req & ~(ack_clr | sw_req_clr)) | hw_req | sw_req_set;
        st_d.en  = (st_q.en & ~sw_en_clr) | sw_en_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc_mask = NSRC'(1) << reg_addr;

    // R1: flags are empty on the first edge after reset
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q == '0));

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R2 / R11: a hardware set always lands, whatever clears the flag
        p_hw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hw_req[i] |=> st_q.req[i]);
    end

    // R3: a CPU request can only come with the wake line up
    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> wake);
    // R6: with both shared sources live, pin D survives the acknowledge
    p_shared_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_vec == 3'd0 && src_vrq[SRC_BTMR] && src_vrq[SRC_PIN_D])
        |=> st_q.req[SRC_PIN_D]);
    // R8: test-and-clear with no racing set leaves the flag at 0
    p_tstclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TSTC && hw_req == '0) |=> ((st_q.req & $past(tc_mask)) == '0));
endmodule

// File: tb/sim_vint_flag_ctrl.sv
`timescale 1ns/1ps
module sim_vint_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] hw_req = '0;
    logic       master_en = 1'b0;
    logic [2:0] reg_op = '0;
    logic [3:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_vec = '0;
    logic [8:0] src_vrq;
    logic       cpu_req;
    logic [2:0] cpu_vec;
    logic       wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vint_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .master_en(master_en),
        .reg_op(reg_op), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .src_vrq(src_vrq), .cpu_req(cpu_req), .cpu_vec(cpu_vec), .wake(wake)
    );

    // stim: hw(9) op(3) addr(4) wd(4) ackv(1) ackvec(3) me(1); exp: vrq(9) creq(1) cvec(3) wake(1)
    function automatic logic [38:0] mk(logic [8:0] hw, logic [2:0] op, logic [3:0] ad,
                                       logic [3:0] wd, logic av, logic [2:0] avec, logic me,
                                       logic [8:0] vrq, logic creq, logic [2:0] cv, logic wk);
        return {hw, op, ad, wd, av, avec, me, vrq, creq, cv, wk};
    endfunction

    localparam int NROW = 17;
    localparam logic [38:0] TBL [NROW] = '{
        mk(9'h000, 3'd3, 4'd0, 4'h0, 1'b0, 3'd0, 1'b1, 9'h000, 1'b0, 3'd0, 1'b0), // R9 enable A
        mk(9'h001, 3'd0, 4'd0, 4'h0, 1'b0, 3'd0, 1'b1, 9'h001, 1'b1, 3'd1, 1'b1), // R2 R3 R4
        mk(9'h000, 3'd0, 4'd0, 4'h0, 1'b1, 3'd1, 1'b1, 9'h000, 1'b0, 3'd0, 1'b0), // R5
        mk(9'h000, 3'd7, 4'd3, 4'hA, 1'b0, 3'd0, 1'b1, 9'h000, 1'b0, 3'd0, 1'b0), // R10 write
        mk(9'h00A, 3'd0, 4'd0, 4'h0, 1'b0, 3'd0, 1'b0, 9'h00A, 1'b0, 3'd0, 1'b1), // R3 wake w/o me
        mk(9'h010, 3'd3, 4'd4, 4'h0, 1'b0, 3'd0, 1'b1, 9'h01A, 1'b1, 3'd0, 1'b1), // R4
        mk(9'h000, 3'd0, 4'd0, 4'h0, 1'b1, 3'd0, 1'b1, 9'h00A, 1'b1, 3'd0, 1'b1), // R6 timer first
        mk(9'h000, 3'd0, 4'd0, 4'h0, 1'b1, 3'd0, 1'b1, 9'h002, 1'b1, 3'd2, 1'b1), // R6 then pin D
        mk(9'h000, 3'd2, 4'd1, 4'h0, 1'b0, 3'd0, 1'b1, 9'h000, 1'b0, 3'd0, 1'b0), // R9 clear pend
        mk(9'h000, 3'd3, 4'd2, 4'h0, 1'b0, 3'd0, 1'b1, 9'h000, 1'b0, 3'd0, 1'b0), // R9
        mk(9'h000, 3'd1, 4'd2, 4'h0, 1'b0, 3'd0, 1'b1, 9'h004, 1'b1, 3'd7, 1'b1), // R7 sw set
        mk(9'h100, 3'd0, 4'd0, 4'h0, 1'b0, 3'd0, 1'b1, 9'h004, 1'b1, 3'd7, 1'b1), // R3 disabled
        mk(9'h000, 3'd3, 4'd8, 4'h0, 1'b0, 3'd0, 1'b1, 9'h104, 1'b1, 3'd6, 1'b1), // R4 prio
        mk(9'h000, 3'd4, 4'd8, 4'h0, 1'b0, 3'd0, 1'b1, 9'h004, 1'b1, 3'd7, 1'b1), // R9 disable
        mk(9'h000, 3'd0, 4'd0, 4'h0, 1'b0, 3'd0, 1'b0, 9'h004, 1'b0, 3'd7, 1'b1), // R4 gate
        mk(9'h004, 3'd0, 4'd0, 4'h0, 1'b1, 3'd7, 1'b1, 9'h004, 1'b1, 3'd7, 1'b1), // R11
        mk(9'h000, 3'd0, 4'd0, 4'h0, 1'b1, 3'd7, 1'b1, 9'h000, 1'b0, 3'd0, 1'b0)  // R5
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] hw, input logic [2:0] op, input logic [3:0] ad,
                         input logic [3:0] wd, input logic av, input logic [2:0] avec,
                         input logic me);
        @(negedge clk);
        hw_req = hw; reg_op = op; reg_addr = ad; reg_wdata = wd;
        ack_valid = av; ack_vec = avec; master_en = me;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        drive(9'h000, 3'd0, 4'd0, 4'h0, 1'b0, 3'd0, master_en);
    endtask

    task automatic grd(input logic [3:0] g, input logic [3:0] exp, input string tag);
        drive(9'h000, 3'd6, g, 4'h0, 1'b0, 3'd0, master_en);
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset vrq", 32'(src_vrq), 0);
        chk("R1 reset cpu_req/wake", 32'({cpu_req, wake, cpu_vec}), 0);
        for (int g = 0; g < 6; g++) grd(4'(g), 4'h0, "R1 reset group");

        for (int i = 0; i < NROW; i++) begin
            logic [38:0] r;
            r = TBL[i];
            drive(r[38:30], r[29:27], r[26:23], r[22:19], r[18], r[17:15], r[14]);
            settle();
            chk($sformatf("row %0d vrq R3", i), 32'(src_vrq), 32'(r[13:5]));
            chk($sformatf("row %0d cpu_req R4", i), 32'(cpu_req), 32'(r[4]));
            chk($sformatf("row %0d cpu_vec R4", i), 32'(cpu_vec), 32'(r[3:1]));
            chk($sformatf("row %0d wake R3", i), 32'(wake), 32'(r[0]));
            idle();
        end

        // R10 group reads: pend {8}, perm [7:4] and [3:0]
        grd(4'd2, 4'h1, "R10 pend grp2");
        grd(4'd4, 4'h1, "R10 perm grp4");
        grd(4'd3, 4'hE, "R10 perm grp3");

        // R8 test-and-clear of a set flag
        drive(9'h000, 3'd5, 4'd8, 4'h0, 1'b0, 3'd0, 1'b1);
        #1; chk("R8 tstclr value", 32'(reg_rdata), 1);
        settle();
        grd(4'd2, 4'h0, "R8 tstclr cleared");

        // R8 race with a hardware set
        drive(9'h000, 3'd1, 4'd5, 4'h0, 1'b0, 3'd0, 1'b1);
        settle();
        drive(9'h020, 3'd5, 4'd5, 4'h0, 1'b0, 3'd0, 1'b1);
        #1; chk("R8 race value", 32'(reg_rdata), 1);
        settle();
        grd(4'd1, 4'h2, "R8 race kept");
        drive(9'h000, 3'd5, 4'd6, 4'h0, 1'b0, 3'd0, 1'b1);
        #1; chk("R8 tstclr zero", 32'(reg_rdata), 0);
        settle();

        // R6 only pin D live: timer flag pending but disabled
        drive(9'h000, 3'd4, 4'd4, 4'h0, 1'b0, 3'd0, 1'b1);
        settle();
        drive(9'h018, 3'd0, 4'd0, 4'h0, 1'b0, 3'd0, 1'b1);
        settle();
        chk("R6 pin D live", 32'(src_vrq), 32'h008);
        drive(9'h000, 3'd0, 4'd0, 4'h0, 1'b1, 3'd0, 1'b1);
        settle();
        grd(4'd1, 4'h3, "R6 timer kept");
        grd(4'd0, 4'h0, "R6 pin D cleared");

        // R11 clear command racing a hardware set
        drive(9'h010, 3'd2, 4'd4, 4'h0, 1'b0, 3'd0, 1'b1);
        settle();
        grd(4'd1, 4'h3, "R11 set beats clear");

        // R7 enabling a software-set flag raises its vector
        drive(9'h000, 3'd3, 4'd5, 4'h0, 1'b0, 3'd0, 1'b1);
        settle();
        chk("R7 vrq", 32'(src_vrq), 32'h020);
        chk("R7 vec", 32'({cpu_req, cpu_vec}), 32'({1'b1, 3'd3}));
        idle();

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 midrun vrq", 32'(src_vrq), 0);
        chk("R1 midrun outs", 32'({cpu_req, wake, cpu_vec}), 0);
        for (int g = 0; g < 6; g++) grd(4'(g), 4'h0, "R1 midrun group");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule